// File: doc/BRIEF.md
# Outbound Message Descriptor Ring Engine

This block drains a circular ring of 32-byte transmit descriptors held in system memory and turns each one into a request on a simple link-side transmit port. Software places the ring at an aligned base address, chooses its size as a power of two from 2 to 2048 entries, and switches the unit on through a small register interface. After filling a descriptor in memory, software bumps the producer pointer by writing a self-clearing increment bit in the mode register.

Whenever the unit is on and the consumer pointer lags the producer pointer, the engine reads four words of the descriptor at the consumer pointer through a single-outstanding memory read port. These are the source address, the mailbox, the destination identifier and the byte count. It then presents them to the transmit port and waits for the link to report completion or failure. Completion moves the consumer pointer on by one slot with wrap. Sticky write-one-to-clear flags record end-of-message, transmission error and rejected increments, and their OR drives the interrupt line.

Top module: `omsg_ring_engine`

## Requirements
- R1: After reset the mode, base, producer and consumer registers read 0, status reads 0x01 (empty), irq is low and neither mem_req nor tx_valid is asserted.
- R2: A write to the base register (address 2) stores the data with its low 5 bits cleared into the base, producer and consumer registers, leaving the ring empty (status bit 0 set); the write is ignored while the engine is busy.
- R3: Writing the mode register (address 0) with bit 1 set advances the producer pointer (address 4) by 32 bytes, returning to the base after 2^(code+1) slots, where code is mode bits 15:12; bit 0 of the mode register is the enable, and bit 1 always reads back as 0.
- R4: An increment that would make the producer pointer equal the consumer pointer leaves the producer pointer unchanged and sets the overflow flag (status bit 5); status bit 4 (full) reads 1 whenever one more increment would overflow.
- R5: The engine starts a descriptor only while enabled and while the producer and consumer pointers differ; it reads the words at consumer+4, +8, +12 and +24 in that order, holding mem_req and mem_addr steady until mem_rvalid.
- R6: The transmit request carries tx_addr = word at +4, tx_mbox = bits 1:0 of word at +8, tx_dest = bits DEST_W+1:2 of word at +12 and tx_size = word at +24, and stays valid and stable until tx_ready.
- R7: A tx_done pulse after the handshake sets end-of-message (status bit 1) and a tx_err pulse sets transmission error (status bit 7); either moves the consumer pointer (address 3) forward one slot with the same wrap as R3.
- R8: Writing 1 to status bits 7, 5 or 1 clears that flag, writing other bits has no effect, and irq is high exactly when one of those three flags is set.
- R9: Status bit 2 (busy) reads 1 from the start of a descriptor fetch until its completion; status bit 0 reads 1 exactly when the pointers are equal.
- R10: Clearing the enable bit stops new descriptors from starting, while a descriptor already started runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 mode, 1 status, 2 base, 3 consumer, 4 producer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit request valid |
| tx_ready | input | 1 | Transmit port accepts the request |
| tx_addr | output | 32 | Source buffer address |
| tx_size | output | 32 | Transfer byte count |
| tx_mbox | output | 2 | Destination mailbox |
| tx_dest | output | DEST_W | Destination identifier |
| tx_done | input | 1 | Transfer finished without error |
| tx_err | input | 1 | Transfer finished with an error |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps ring sizes of 2, 4 and 8 slots with misaligned base writes, filling each ring to the point of overflow so that the last accepted increment, the rejected one and the full flag are told apart. Descriptor contents come from an address hash in the bench memory, and read latency varies with the address, so a wrong word offset, a wrong field slice or a request dropped before mem_rvalid shows up as a field mismatch. Each ring is drained with completions and one error to separate the two flags, then refilled past its end to exercise producer and consumer wrap. A disabled ring with work pending, a disable issued mid-fetch and a base write issued while busy cover the gating rules.

// File: rtl/omsg_pkg.sv
package omsg_pkg;
    localparam int WORD_W     = 32;
    localparam int SLOT_BYTES = 32;
    localparam int CODE_W     = 4;

    typedef enum logic [2:0] {
        RA_MODE = 3'd0,
        RA_STAT = 3'd1,
        RA_BASE = 3'd2,
        RA_DEQ  = 3'd3,
        RA_ENQ  = 3'd4
    } reg_sel_e;

    localparam int SB_EMPTY = 0;
    localparam int SB_EOM   = 1;
    localparam int SB_BUSY  = 2;
    localparam int SB_FULL  = 4;
    localparam int SB_OVF   = 5;
    localparam int SB_TERR  = 7;

    localparam int MB_EN   = 0;
    localparam int MB_INC  = 1;
    localparam int MB_CODE = 12;

    typedef enum logic [1:0] {
        FX_IDLE,
        FX_FETCH,
        FX_SEND,
        FX_WAIT
    } fx_state_e;

    // byte offset of the n-th fetched descriptor word
    function automatic logic [4:0] word_offset(input logic [1:0] idx);
        case (idx)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd24;
        endcase
    endfunction
endpackage

// File: rtl/omsg_ring_step.sv
module omsg_ring_step
    import omsg_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LOG2_MAX = 11
) (
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     ptr,
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     nxt
);
    localparam int MAX_CODE = LOG2_MAX - 1;

    logic [CODE_W-1:0] code_c;
    logic [AW-1:0]     span;
    logic [AW-1:0]     off;

    always_comb begin
        code_c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        span   = AW'(SLOT_BYTES) << (code_c + 1'b1);
        off    = ptr - base + AW'(SLOT_BYTES);
        nxt    = (off >= span) ? base : ptr + AW'(SLOT_BYTES);
    end
endmodule

// File: rtl/omsg_fetch.sv
module omsg_fetch
    import omsg_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DEST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     deq_ptr,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_addr,
    output logic [WORD_W-1:0] tx_size,
    output logic [1:0]        tx_mbox,
    output logic [DEST_W-1:0] tx_dest,
    input  logic              tx_done,
    input  logic              tx_err,
    output logic              busy,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        fx_state_e         st;
        logic [1:0]        widx;
        logic [WORD_W-1:0] saddr;
        logic [1:0]        mbox;
        logic [DEST_W-1:0] dest;
        logic [WORD_W-1:0] size;
    } fx_t;

    fx_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        err_o  = 1'b0;
        case (q.st)
            FX_IDLE: begin
                if (start) begin
                    d.st   = FX_FETCH;
                    d.widx = 2'd0;
                end
            end
            FX_FETCH: begin
                if (mem_rvalid) begin
                    case (q.widx)
                        2'd0:    d.saddr = mem_rdata;
                        2'd1:    d.mbox  = mem_rdata[1:0];
                        2'd2:    d.dest  = mem_rdata[DEST_W+1:2];
                        default: d.size  = mem_rdata;
                    endcase
                    if (q.widx == 2'd3) d.st = FX_SEND;
                    else                d.widx = q.widx + 2'd1;
                end
            end
            FX_SEND: begin
                if (tx_ready) d.st = FX_WAIT;
            end
            default: begin
                if (tx_done) begin
                    done_o = 1'b1;
                    d.st   = FX_IDLE;
                end else if (tx_err) begin
                    err_o  = 1'b1;
                    d.st   = FX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: FX_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_req  = (q.st == FX_FETCH);
    assign mem_addr = deq_ptr + AW'(word_offset(q.widx));
    assign tx_valid = (q.st == FX_SEND);
    assign tx_addr  = q.saddr;
    assign tx_size  = q.size;
    assign tx_mbox  = q.mbox;
    assign tx_dest  = q.dest;
    assign busy     = (q.st != FX_IDLE);

    // R5: a read request is held with a steady address until data returns
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R6: the transmit request is held unchanged until accepted
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_size)
                                  && $stable(tx_mbox) && $stable(tx_dest));
endmodule

// File: rtl/omsg_ring_engine.sv
module omsg_ring_engine
    import omsg_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DEST_W   = 8,
    parameter int LOG2_MAX = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_addr,
    output logic [WORD_W-1:0] tx_size,
    output logic [1:0]        tx_mbox,
    output logic [DEST_W-1:0] tx_dest,
    input  logic              tx_done,
    input  logic              tx_err,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [AW-1:0]     base;
        logic [AW-1:0]     enq;
        logic [AW-1:0]     deq;
        logic              terr;
        logic              ovf;
        logic              eom;
    } eng_t;

    eng_t q, d;

    logic [AW-1:0] enq_nxt, deq_nxt;
    logic          busy, fx_done, fx_err;
    logic          ring_empty, ring_full;
    logic          wr_mode, wr_stat, wr_base;

    omsg_ring_step #(.AW(AW), .LOG2_MAX(LOG2_MAX)) u_enq_step (
        .base(q.base), .ptr(q.enq), .code(q.code), .nxt(enq_nxt));

    omsg_ring_step #(.AW(AW), .LOG2_MAX(LOG2_MAX)) u_deq_step (
        .base(q.base), .ptr(q.deq), .code(q.code), .nxt(deq_nxt));

    omsg_fetch #(.AW(AW), .DEST_W(DEST_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start(q.en && !ring_empty), .deq_ptr(q.deq),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_addr(tx_addr), .tx_size(tx_size), .tx_mbox(tx_mbox), .tx_dest(tx_dest),
        .tx_done(tx_done), .tx_err(tx_err),
        .busy(busy), .done_o(fx_done), .err_o(fx_err));

    assign ring_empty = (q.enq == q.deq);
    assign ring_full  = (enq_nxt == q.deq);
    assign wr_mode    = reg_wr && (reg_addr == RA_MODE);
    assign wr_stat    = reg_wr && (reg_addr == RA_STAT);
    assign wr_base    = reg_wr && (reg_addr == RA_BASE);

    always_comb begin
        d = q;
        if (wr_mode) begin
            d.en   = reg_wdata[MB_EN];
            d.code = reg_wdata[MB_CODE +: CODE_W];
            if (reg_wdata[MB_INC]) begin
                if (ring_full) d.ovf = 1'b1;
                else           d.enq = enq_nxt;
            end
        end
        if (wr_stat) begin
            if (reg_wdata[SB_TERR]) d.terr = 1'b0;
            if (reg_wdata[SB_OVF])  d.ovf  = 1'b0;
            if (reg_wdata[SB_EOM])  d.eom  = 1'b0;
        end
        if (wr_base && !busy) begin
            d.base = AW'(reg_wdata & ~WORD_W'(SLOT_BYTES - 1));
            d.enq  = d.base;
            d.deq  = d.base;
        end
        if (fx_done || fx_err) begin
            d.deq  = deq_nxt;
            d.eom  = q.eom  | fx_done;
            d.terr = q.terr | fx_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: begin
                reg_rdata[MB_EN]              = q.en;
                reg_rdata[MB_CODE +: CODE_W]  = q.code;
            end
            RA_STAT: begin
                reg_rdata[SB_TERR]  = q.terr;
                reg_rdata[SB_OVF]   = q.ovf;
                reg_rdata[SB_FULL]  = ring_full;
                reg_rdata[SB_BUSY]  = busy;
                reg_rdata[SB_EOM]   = q.eom;
                reg_rdata[SB_EMPTY] = ring_empty;
            end
            RA_BASE: reg_rdata = WORD_W'(q.base);
            RA_DEQ:  reg_rdata = WORD_W'(q.deq);
            RA_ENQ:  reg_rdata = WORD_W'(q.enq);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = q.terr | q.ovf | q.eom;

    // R4: a rejected increment keeps the producer pointer and raises overflow
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && reg_wdata[MB_INC] && ring_full |=> $stable(q.enq) && q.ovf);

    // R5: no descriptor read while the ring is empty
    p_fetch_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ring_empty);

    // R7: the consumer pointer moves only on completion or a base load
    p_deq_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fx_done && !fx_err && !wr_base |=> $stable(q.deq));

    // R8: end-of-message stays set until cleared by a write of 1
    p_eom_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.eom && !(wr_stat && reg_wdata[SB_EOM]) |=> q.eom);

    // R10: nothing starts while the unit is disabled and idle
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en && !busy |=> !mem_req);
endmodule

// File: tb/omsg_ring_engine_test.sv
`timescale 1ns/1ps
module omsg_ring_engine_test;
    localparam int DEST_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_addr, tx_size;
    logic [1:0]  tx_mbox;
    logic [DEST_W-1:0] tx_dest;
    logic        tx_done = 1'b0;
    logic        tx_err = 1'b0;
    logic        irq;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    omsg_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_addr(tx_addr), .tx_size(tx_size), .tx_mbox(tx_mbox), .tx_dest(tx_dest),
        .tx_done(tx_done), .tx_err(tx_err), .irq(irq));

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ (a >> 3) ^ 32'h5A5A0F0F;
    endfunction

    assign mem_rdata = mem_val(mem_addr);

    // memory responder: latency depends on address bits 4:3
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) mem_rvalid = 1'b0;
            else if (mem_req) begin
                if (lat >= int'(mem_addr[4:3])) begin
                    mem_rvalid = 1'b1;
                    lat = 0;
                end else lat++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // bench ring model
    logic [31:0] m_base, m_enq, m_deq;
    int          m_slots;

    function automatic logic [31:0] step(input logic [31:0] p);
        return (p - m_base + 32 >= 32'(m_slots * 32)) ? m_base : p + 32;
    endfunction

    task automatic serve(input bit inject_err);
        logic [31:0] v;
        int n = 0;
        while (!tx_valid && n < 100) begin @(negedge clk); n++; end
        chk("R5 descriptor fetched", {31'b0, tx_valid}, 32'd1);
        chk("R6 tx_addr", tx_addr, mem_val(m_deq + 4));
        chk("R6 tx_mbox", {30'b0, tx_mbox}, {30'b0, mem_val(m_deq + 8) & 32'h3});
        chk("R6 tx_dest", {24'b0, tx_dest}, (mem_val(m_deq + 12) >> 2) & 32'hFF);
        chk("R6 tx_size", tx_size, mem_val(m_deq + 24));
        rd(3'd1, v);
        chk("R9 busy while sending", v & 32'h4, 32'h4);
        chk("R6 held until ready", {31'b0, tx_valid}, 32'd1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R6 valid drops after accept", {31'b0, tx_valid}, 32'd0);
        @(negedge clk);
        if (inject_err) tx_err = 1'b1; else tx_done = 1'b1;
        @(negedge clk);
        tx_err = 1'b0; tx_done = 1'b0;
        m_deq = step(m_deq);
        rd(3'd3, v);
        chk("R7 consumer advance", v, m_deq);
        rd(3'd1, v);
        chk("R7 completion flag", v & 32'h82, inject_err ? 32'h80 : 32'h02);
        chk("R8 irq set", {31'b0, irq}, 32'd1);
        wr(3'd1, 32'h82);
        chk("R8 irq cleared", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        #(8ns * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, v); chk("R1 mode", v, 32'h0);
        rd(3'd1, v); chk("R1 status", v, 32'h1);
        rd(3'd2, v); chk("R1 base", v, 32'h0);
        rd(3'd3, v); chk("R1 consumer", v, 32'h0);
        rd(3'd4, v); chk("R1 producer", v, 32'h0);
        chk("R1 outputs idle", {29'b0, irq, mem_req, tx_valid}, 32'h0);

        for (int c = 0; c < 3; c++) begin
            m_slots = 2 << c;
            wr(3'd0, 32'(c) << 12);
            wr(3'd2, 32'h1000 * (c + 1) + 32'h13);
            m_base = 32'h1000 * (c + 1);
            m_enq = m_base; m_deq = m_base;
            rd(3'd2, v); chk("R2 base aligned", v, m_base);
            rd(3'd4, v); chk("R2 producer loaded", v, m_base);
            rd(3'd3, v); chk("R2 consumer loaded", v, m_base);
            rd(3'd1, v); chk("R2 empty after base", v, 32'h1);
            // fill until one increment is rejected
            for (int i = 0; i < m_slots; i++) begin
                wr(3'd0, (32'(c) << 12) | 32'h2);
                if (i < m_slots - 1) m_enq = step(m_enq);
                rd(3'd4, v); chk("R3 producer increment", v, m_enq);
            end
            rd(3'd1, v); chk("R4 full and overflow", v, 32'h30);
            chk("R8 irq on overflow", {31'b0, irq}, 32'd1);
            wr(3'd1, 32'h20);
            wr(3'd1, 32'h15);
            rd(3'd1, v); chk("R8 only overflow cleared", v, 32'h10);
            rd(3'd0, v); chk("R3 increment reads zero", v, 32'(c) << 12);
            // enable and drain
            wr(3'd0, (32'(c) << 12) | 32'h1);
            for (int i = 0; i < m_slots - 1; i++) serve(c == 1 && i == 1);
            repeat (3) @(negedge clk);
            rd(3'd1, v); chk("R9 empty after drain", v, 32'h1);
            // wrap of both pointers
            wr(3'd0, (32'(c) << 12) | 32'h3);
            m_enq = step(m_enq);
            rd(3'd4, v); chk("R3 producer wrap", v, m_enq);
            chk("R3 wrap lands on base", m_enq, m_base);
            serve(1'b0);
            chk("R7 consumer wrap", m_deq, m_base);
        end

        // R10: disabled ring with work pending stays idle
        wr(3'd0, (32'd1 << 12) | 32'h2);
        m_enq = step(m_enq);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (mem_req || tx_valid) seen = 1'b1;
            end
            chk("R10 no start while disabled", {31'b0, seen}, 32'd0);
        end
        wr(3'd0, 32'd1 << 12 | 32'h1);
        serve(1'b0);
        // R10 disable mid-fetch; R2 base write while busy ignored
        wr(3'd0, (32'd1 << 12) | 32'h3);
        m_enq = step(m_enq);
        begin
            int n = 0;
            while (!mem_req && n < 50) begin @(negedge clk); n++; end
        end
        wr(3'd0, 32'd1 << 12);
        wr(3'd2, 32'h9000);
        serve(1'b0);
        rd(3'd2, v); chk("R2 base write ignored when busy", v, m_base);
        rd(3'd0, v); chk("R10 mode after disable", v, 32'd1 << 12);
        repeat (3) @(negedge clk);
        rd(3'd1, v); chk("R10 ring drained and idle", v, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule